// File: doc/BRIEF.md
# Multi-Target SMBus Write Sequencer

This block sends one payload to several SMBus targets in turn. While it is idle, a host fills two buffers: a list of 7-bit target addresses and a list of payload bytes. A start pulse then asks the sequencer to run the whole command. If the combined entry count fits the shared budget, the sequencer visits every listed address in order. For each one it runs a complete write transaction on a byte-level bus engine: a start, the address byte with the write bit, every payload byte, and a stop.

The engine is reached through a small handshake. A one-cycle request carries an opcode and a byte, and the engine answers with a response pulse that carries an acknowledge or not-acknowledge result. The sequencer watches each target's transfer with an optional down-counting timeout. The timeout is loaded again for every target. A target that refuses a byte or runs out of time is skipped. Its outcome goes into a per-target status vector, and a done pulse marks the end of the list.

Top module: `smbus_fanout_seq`

## Requirements
- R1: While idle, each `addr_wr` cycle appends `addr_in` to the address list and each `data_wr` cycle appends `data_in` to the payload, both in arrival order.
- R2: A `go` pulse while idle is rejected when the address list is empty, when the address count plus the payload count exceeds BUDGET, or when either list was written past its depth. A rejected `go` gives a one-cycle `err_reject` in the next cycle, makes no engine request and empties both lists.
- R3: No engine request is made before an accepted `go`. The lists are complete by then, so every target is sent from the full command.
- R4: Targets are visited from index 0 in list order. Each transfer is START (`eng_op`=1), WRITE (`eng_op`=2) of {address, 0}, a WRITE of each payload byte in order, then STOP (`eng_op`=3). Every target receives the identical payload.
- R5: `eng_req` is high for one cycle per operation. No further request is made until `eng_rsp` arrives, and `eng_nack` qualifies that response.
- R6: A not-acknowledge on the address byte or on any payload byte sends no more bytes to that target, issues STOP, records NACK (2'b10) and moves to the next address.
- R7: With `tmo_cycles`=T>0, a timer is loaded with T when each target's START phase begins. If it runs out before that target's STOP response, the target is abandoned with no further request for it, its status becomes TIMEOUT (2'b11) and the next target begins.
- R8: With `tmo_cycles`=0 the timeout is disabled, so a slow engine never causes a TIMEOUT.
- R9: Target i reports in `status_vec[2i+1:2i]`: 2'b01 OK, 2'b00 not processed. The vector is cleared by an accepted `go` and holds its value after completion.
- R10: `busy` is high from the cycle after an accepted `go` through the cycle of a one-cycle `done` pulse, which follows the last target. Both lists are then empty.
- R11: While busy, `go`, `addr_wr` and `data_wr` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Append `addr_in` to the address list |
| addr_in | input | 7 | Target address |
| data_wr | input | 1 | Append `data_in` to the payload |
| data_in | input | 8 | Payload byte |
| go | input | 1 | Run the loaded command |
| tmo_cycles | input | TMO_W | Per-target timeout in clock cycles, 0 disables it |
| eng_req | output | 1 | One-cycle request to the byte engine |
| eng_op | output | 2 | Opcode: 1 START, 2 WRITE, 3 STOP |
| eng_wdata | output | 8 | Byte for WRITE |
| eng_rsp | input | 1 | Engine response pulse |
| eng_nack | input | 1 | Response is a not-acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after the last target |
| err_reject | output | 1 | One-cycle pulse for a rejected `go` |
| status_vec | output | 2*ADDR_DEPTH | Per-target result codes |

## Verification
The bench builds the block with ADDR_DEPTH=6, DATA_DEPTH=20, BUDGET=20 and TMO_W=8. With these values the exact budget edge (4 addresses plus 16 bytes accepted, 17 bytes rejected) and a depth overrun (a 7th address) take only a few dozen cycles. A behavioural engine model with adjustable latency, selectable not-acknowledges and a hang mode brings every outcome within reach. The short timeouts (10 and 50) can then be shown both to expire on a hung target and to re-arm for each target, since a 3-target run outlasts one timeout while each target alone fits inside it.

// File: rtl/fanout_pkg.sv
`timescale 1ns/1ps
package fanout_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'b00, ST_OK = 2'b01, ST_NACK = 2'b10, ST_TMO = 2'b11
  } tgt_status_e;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0, OP_START = 2'd1, OP_WRITE = 2'd2, OP_STOP = 2'd3
  } eng_op_e;

  // Shared budget: at least one address and combined count within limit
  function automatic logic budget_ok(logic [15:0] n_addr, logic [15:0] n_data,
                                     logic [15:0] limit);
    return (n_addr != 16'd0) &&
           (({1'b0, n_addr} + {1'b0, n_data}) <= {1'b0, limit});
  endfunction

  // Address phase byte: 7-bit address followed by the write bit (0)
  function automatic logic [7:0] addr_byte(logic [6:0] a);
    return {a, 1'b0};
  endfunction
endpackage

// File: rtl/fanout_buf.sv
`timescale 1ns/1ps
module fanout_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0] mem [DEPTH];
  logic full;
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (wr_en) begin
      if (full) ovf <= 1'b1;
      else      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr && !full) mem[count[IW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_overrun_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && count == CW'(DEPTH)) |=> ovf);
endmodule

// File: rtl/fanout_timer.sv
`timescale 1ns/1ps
module fanout_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          halt,
  input  logic [TW-1:0] limit,
  output logic          running,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (arm)           cnt <= limit;
    else if (halt)          cnt <= '0;
    else if (cnt != '0)     cnt <= cnt - TW'(1);
  end

  assign running = (cnt != '0);
  assign expired = (cnt == TW'(1)) && !halt && !arm;

  p_zero_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && limit == '0) |=> !running);
  p_arm_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && limit != '0) |=> running);
endmodule

// File: rtl/fanout_seq.sv
`timescale 1ns/1ps
module fanout_seq import fanout_pkg::*; #(
  parameter int ADDR_DEPTH = 32,
  parameter int DATA_DEPTH = 255,
  parameter int BUDGET     = 255,
  localparam int AIW = (ADDR_DEPTH > 1) ? $clog2(ADDR_DEPTH) : 1,
  localparam int ACW = $clog2(ADDR_DEPTH + 1),
  localparam int DIW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
  localparam int DCW = $clog2(DATA_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [ACW-1:0]          a_cnt,
  input  logic                    a_ovf,
  input  logic [6:0]              a_byte,
  output logic [AIW-1:0]          a_idx,
  input  logic [DCW-1:0]          d_cnt,
  input  logic                    d_ovf,
  input  logic [7:0]              d_byte,
  output logic [DIW-1:0]          d_idx,
  output logic                    buf_clr,
  output logic                    tmr_arm,
  output logic                    tmr_halt,
  input  logic                    expired,
  output logic                    eng_req,
  output logic [1:0]              eng_op,
  output logic [7:0]              eng_wdata,
  input  logic                    eng_rsp,
  input  logic                    eng_nack,
  output logic                    busy,
  output logic                    done,
  output logic                    err_reject,
  output logic [2*ADDR_DEPTH-1:0] status_vec
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_DATA, S_STOP, S_NEXT, S_FIN} state_e;
  state_e state;
  logic pend;
  logic [AIW-1:0] ti;
  logic [DIW-1:0] di;
  tgt_status_e status [ADDR_DEPTH];

  logic accept, reject, in_op, last_tgt, last_byte;
  assign accept = (state == S_IDLE) && go && !a_ovf && !d_ovf &&
                  budget_ok(16'(a_cnt), 16'(d_cnt), 16'(BUDGET));
  assign reject = (state == S_IDLE) && go && !accept;
  assign in_op  = (state == S_START) || (state == S_ADDR) ||
                  (state == S_DATA)  || (state == S_STOP);
  assign last_tgt  = (ti == AIW'(a_cnt - ACW'(1)));
  assign last_byte = (di == DIW'(d_cnt - DCW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pend <= 1'b0; ti <= '0; di <= '0; err_reject <= 1'b0;
      for (int i = 0; i < ADDR_DEPTH; i++) status[i] <= ST_NONE;
    end else begin
      err_reject <= reject;
      if (state == S_IDLE) begin
        if (accept) begin
          for (int i = 0; i < ADDR_DEPTH; i++) status[i] <= ST_NONE;
          ti <= '0; state <= S_START;
        end
      end else if (in_op) begin
        if (expired) begin
          status[ti] <= ST_TMO; pend <= 1'b0; state <= S_NEXT;
        end else if (!pend) begin
          pend <= 1'b1;
        end else if (eng_rsp) begin
          pend <= 1'b0;
          case (state)
            S_START: state <= S_ADDR;
            S_ADDR: begin
              di <= '0;
              if (eng_nack) begin status[ti] <= ST_NACK; state <= S_STOP; end
              else if (d_cnt == '0) state <= S_STOP;
              else state <= S_DATA;
            end
            S_DATA: begin
              if (eng_nack) begin status[ti] <= ST_NACK; state <= S_STOP; end
              else if (last_byte) state <= S_STOP;
              else di <= di + DIW'(1);
            end
            default: begin
              if (status[ti] == ST_NONE) status[ti] <= ST_OK;
              state <= S_NEXT;
            end
          endcase
        end
      end else if (state == S_NEXT) begin
        if (last_tgt) state <= S_FIN;
        else begin ti <= ti + AIW'(1); state <= S_START; end
      end else begin
        state <= S_IDLE;
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign buf_clr  = reject || (state == S_FIN);
  assign tmr_arm  = accept || ((state == S_NEXT) && !last_tgt);
  assign tmr_halt = (state == S_NEXT);
  assign a_idx    = ti;
  assign d_idx    = di;
  assign eng_req  = in_op && !pend && !expired;

  always_comb begin
    eng_op    = OP_NOP;
    eng_wdata = 8'h00;
    case (state)
      S_START: eng_op = OP_START;
      S_ADDR:  begin eng_op = OP_WRITE; eng_wdata = addr_byte(a_byte); end
      S_DATA:  begin eng_op = OP_WRITE; eng_wdata = d_byte; end
      S_STOP:  eng_op = OP_STOP;
      default: ;
    endcase
  end

  for (genvar g = 0; g < ADDR_DEPTH; g++) begin : g_stat
    assign status_vec[2*g +: 2] = status[g];
  end

  p_single_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_reject && !busy && !eng_req));
  p_timeout_skips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && in_op) |=> (state == S_NEXT && !eng_req));
  p_busy_go_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> !err_reject);
endmodule

// File: rtl/smbus_fanout_seq.sv
`timescale 1ns/1ps
module smbus_fanout_seq #(
  parameter int ADDR_DEPTH = 32,
  parameter int DATA_DEPTH = 255,
  parameter int BUDGET     = 255,
  parameter int TMO_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addr_wr,
  input  logic [6:0]              addr_in,
  input  logic                    data_wr,
  input  logic [7:0]              data_in,
  input  logic                    go,
  input  logic [TMO_W-1:0]        tmo_cycles,
  output logic                    eng_req,
  output logic [1:0]              eng_op,
  output logic [7:0]              eng_wdata,
  input  logic                    eng_rsp,
  input  logic                    eng_nack,
  output logic                    busy,
  output logic                    done,
  output logic                    err_reject,
  output logic [2*ADDR_DEPTH-1:0] status_vec
);
  localparam int AIW = (ADDR_DEPTH > 1) ? $clog2(ADDR_DEPTH) : 1;
  localparam int ACW = $clog2(ADDR_DEPTH + 1);
  localparam int DIW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;
  localparam int DCW = $clog2(DATA_DEPTH + 1);

  logic [ACW-1:0] a_cnt;
  logic [DCW-1:0] d_cnt;
  logic [AIW-1:0] a_idx;
  logic [DIW-1:0] d_idx;
  logic [6:0] a_byte;
  logic [7:0] d_byte;
  logic a_ovf, d_ovf, buf_clr, tmr_arm, tmr_halt, tmr_run, tmr_exp;

  fanout_buf #(.W(7), .DEPTH(ADDR_DEPTH)) u_abuf (
    .clk, .rst_n, .clr(buf_clr), .wr_en(addr_wr && !busy), .wr_data(addr_in),
    .rd_idx(a_idx), .rd_data(a_byte), .count(a_cnt), .ovf(a_ovf));

  fanout_buf #(.W(8), .DEPTH(DATA_DEPTH)) u_dbuf (
    .clk, .rst_n, .clr(buf_clr), .wr_en(data_wr && !busy), .wr_data(data_in),
    .rd_idx(d_idx), .rd_data(d_byte), .count(d_cnt), .ovf(d_ovf));

  fanout_timer #(.TW(TMO_W)) u_tmr (
    .clk, .rst_n, .arm(tmr_arm), .halt(tmr_halt), .limit(tmo_cycles),
    .running(tmr_run), .expired(tmr_exp));

  fanout_seq #(.ADDR_DEPTH(ADDR_DEPTH), .DATA_DEPTH(DATA_DEPTH), .BUDGET(BUDGET)) u_seq (
    .clk, .rst_n, .go, .a_cnt, .a_ovf, .a_byte, .a_idx, .d_cnt, .d_ovf, .d_byte, .d_idx,
    .buf_clr, .tmr_arm, .tmr_halt, .expired(tmr_exp), .eng_req, .eng_op, .eng_wdata,
    .eng_rsp, .eng_nack, .busy, .done, .err_reject, .status_vec);

  p_timer_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tmr_run);
endmodule

// File: tb/tb_smbus_fanout_seq.sv
`timescale 1ns/1ps
module tb_smbus_fanout_seq;
  localparam int AD = 6, DD = 20, BG = 20, TW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_wr = 0, data_wr = 0, go = 0, eng_rsp = 0, eng_nack = 0;
  logic [6:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic [TW-1:0] tmo_cycles = '0;
  logic eng_req, busy, done, err_reject;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata;
  logic [2*AD-1:0] status_vec;

  smbus_fanout_seq #(.ADDR_DEPTH(AD), .DATA_DEPTH(DD), .BUDGET(BG), .TMO_W(TW)) dut (
    .clk, .rst_n, .addr_wr, .addr_in, .data_wr, .data_in, .go, .tmo_cycles,
    .eng_req, .eng_op, .eng_wdata, .eng_rsp, .eng_nack, .busy, .done,
    .err_reject, .status_vec);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  // engine model configuration and transcript
  int lat = 1;
  int nack_addr = -1, nack_dtgt = -1, nack_dpos = -1, hang_addr = -1;
  logic [1:0] log_op [256];
  logic [7:0] log_b  [256];
  int log_n = 0;
  logic [1:0] exp_op [256];
  logic [7:0] exp_b  [256];
  int exp_n = 0;

  initial begin : engine_model
    int cd, cur, pos;
    logic expect_addr, pn;
    cd = 0; cur = -1; pos = 0; expect_addr = 0; pn = 0;
    forever begin
      @(negedge clk);
      eng_rsp = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin eng_rsp = 1'b1; eng_nack = pn; end
      end else if (eng_req) begin
        if (log_n < 256) begin log_op[log_n] = eng_op; log_b[log_n] = eng_wdata; end
        log_n++;
        pn = 1'b0;
        if (eng_op == 2'd1) expect_addr = 1'b1;
        else if (eng_op == 2'd2 && expect_addr) begin
          expect_addr = 1'b0; cur = int'(eng_wdata[7:1]); pos = 0;
          pn = (cur == nack_addr);
        end else if (eng_op == 2'd2) begin
          pn = (cur == nack_dtgt) && (pos == nack_dpos);
          pos++;
        end
        if (!(eng_op == 2'd2 && cur == hang_addr)) cd = lat;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  // kind: 0 full frame, 1 address refused, 2 byte p refused, 3 hang after address
  task automatic exp_frame(input logic [6:0] a, input logic [7:0] d [DD], input int nd,
                           input int kind, input int p);
    push(2'd1, 8'h00);
    push(2'd2, {a, 1'b0});
    if (kind == 3) return;
    if (kind != 1)
      for (int i = 0; i < nd; i++) begin
        push(2'd2, d[i]);
        if (kind == 2 && i == p) break;
      end
    push(2'd3, 8'h00);
  endtask

  task automatic cmp_log(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_op[i] !== exp_op[i] || log_b[i] !== exp_b[i])) bad = i;
    if (log_n != exp_n) check(0, {tag, " transcript length"}, log_n, exp_n);
    else if (bad >= 0) check(0, {tag, " transcript entry"}, {log_op[bad], log_b[bad]},
                               {exp_op[bad], exp_b[bad]});
    else check(1, tag, 0, 0);
  endtask

  task automatic load(input logic [6:0] a [8], input int na, input logic [7:0] d [DD], input int nd);
    log_n = 0; exp_n = 0;
    for (int i = 0; i < na; i++) begin
      @(negedge clk); addr_wr = 1; addr_in = a[i];
    end
    @(negedge clk); addr_wr = 0;
    for (int i = 0; i < nd; i++) begin
      @(negedge clk); data_wr = 1; data_in = d[i];
    end
    @(negedge clk); data_wr = 0;
  endtask

  task automatic pulse_go(output bit err_seen);
    err_seen = 0;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0; err_seen = err_reject;
    @(negedge clk); err_seen = err_seen | err_reject;
  endtask

  task automatic wait_done(input string tag, output bit seen);
    seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen, {tag, " done pulse"}, seen, 1);
    @(negedge clk);
    check(!done && !busy, {tag, " done one cycle"}, {done, busy}, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err_reject && !eng_req && status_vec == '0,
          "R9 R10 reset state", {busy, done, eng_req, status_vec}, 0);
  endtask

  task automatic t_basic();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h10, 7'h22, 0, 0, 0, 0, 0, 0};
    d = '{default: 8'h0}; d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3;
    lat = 1; tmo_cycles = 0;
    load(a, 2, d, 3);
    check(log_n == 0, "R3 no request before go", log_n, 0);
    pulse_go(e);
    check(!e, "R2 accepted command", e, 0);
    wait_done("R10 basic", s);
    exp_frame(a[0], d, 3, 0, 0); exp_frame(a[1], d, 3, 0, 0);
    cmp_log("R1 R4 basic framing");
    check(status_vec == 12'h005, "R9 basic status", status_vec, 12'h005);
  endtask

  task automatic t_budget_edge();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h01, 7'h02, 7'h03, 7'h04, 0, 0, 0, 0};
    for (int i = 0; i < DD; i++) d[i] = 8'(i * 7 + 3);
    load(a, 4, d, 16);
    pulse_go(e);
    check(!e, "R2 budget edge accepted", e, 0);
    wait_done("R2 budget edge", s);
    for (int i = 0; i < 4; i++) exp_frame(a[i], d, 16, 0, 0);
    cmp_log("R4 identical payload to all targets");
    check(status_vec == 12'h055, "R9 budget edge status", status_vec, 12'h055);
  endtask

  task automatic t_reject();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e;
    a = '{7'h11, 7'h12, 7'h13, 7'h14, 7'h15, 7'h16, 7'h17, 0};
    for (int i = 0; i < DD; i++) d[i] = 8'(i);
    load(a, 4, d, 17);
    pulse_go(e);
    repeat (20) @(negedge clk);
    check(e && log_n == 0 && !busy, "R2 over budget rejected", {e, 8'(log_n)}, 9'h100);
    load(a, 7, d, 1);
    pulse_go(e);
    repeat (20) @(negedge clk);
    check(e && log_n == 0, "R2 depth overrun rejected", {e, 8'(log_n)}, 9'h100);
    load(a, 0, d, 2);
    pulse_go(e);
    repeat (20) @(negedge clk);
    check(e && log_n == 0, "R2 empty address list rejected", {e, 8'(log_n)}, 9'h100);
    check(status_vec == 12'h055, "R9 status held after reject", status_vec, 12'h055);
  endtask

  task automatic t_nack();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h30, 7'h31, 7'h32, 7'h33, 0, 0, 0, 0};
    d = '{default: 8'h0}; d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h03;
    lat = 2; nack_addr = 7'h31; nack_dtgt = 7'h32; nack_dpos = 1;
    load(a, 4, d, 3);
    pulse_go(e);
    wait_done("R6 nack", s);
    exp_frame(a[0], d, 3, 0, 0); exp_frame(a[1], d, 3, 1, 0);
    exp_frame(a[2], d, 3, 2, 1); exp_frame(a[3], d, 3, 0, 0);
    cmp_log("R6 nack transcript");
    check(status_vec == 12'h069, "R6 nack status", status_vec, 12'h069);
    nack_addr = -1; nack_dtgt = -1;
  endtask

  task automatic t_timeout();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h40, 7'h41, 7'h42, 0, 0, 0, 0, 0};
    d = '{default: 8'h0}; d[0] = 8'h99;
    lat = 1; tmo_cycles = 10; hang_addr = 7'h41;
    load(a, 3, d, 1);
    pulse_go(e);
    wait_done("R7 timeout", s);
    exp_frame(a[0], d, 1, 0, 0); exp_frame(a[1], d, 1, 3, 0); exp_frame(a[2], d, 1, 0, 0);
    cmp_log("R7 timeout abandons target");
    check(status_vec == 12'h01D, "R7 timeout status", status_vec, 12'h01D);
    hang_addr = -1;
  endtask

  task automatic t_tmo_off();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h50, 0, 0, 0, 0, 0, 0, 0};
    d = '{default: 8'h0}; d[0] = 8'h5A; d[1] = 8'hA5;
    lat = 40; tmo_cycles = 0;
    load(a, 1, d, 2);
    pulse_go(e);
    wait_done("R8 timeout off", s);
    check(status_vec == 12'h001, "R8 slow engine no timeout", status_vec, 12'h001);
  endtask

  task automatic t_rearm();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h60, 7'h61, 7'h62, 0, 0, 0, 0, 0};
    d = '{default: 8'h0}; for (int i = 0; i < 4; i++) d[i] = 8'(8'h20 + i);
    lat = 2; tmo_cycles = 50;
    load(a, 3, d, 4);
    pulse_go(e);
    wait_done("R7 re-arm", s);
    check(status_vec == 12'h015, "R7 timer reloaded per target", status_vec, 12'h015);
  endtask

  task automatic t_busy_ignore();
    logic [6:0] a [8]; logic [7:0] d [DD]; bit e, s;
    a = '{7'h70, 7'h71, 0, 0, 0, 0, 0, 0};
    d = '{default: 8'h0}; d[0] = 8'h11; d[1] = 8'h22;
    lat = 3; tmo_cycles = 0;
    load(a, 2, d, 2);
    pulse_go(e);
    @(negedge clk); go = 1; addr_wr = 1; addr_in = 7'h7F; data_wr = 1; data_in = 8'hEE;
    @(negedge clk); go = 0; addr_wr = 0; data_wr = 0;
    wait_done("R11 busy", s);
    exp_frame(a[0], d, 2, 0, 0); exp_frame(a[1], d, 2, 0, 0);
    cmp_log("R11 inputs while busy ignored");
    log_n = 0;
    pulse_go(e);
    repeat (10) @(negedge clk);
    check(e && log_n == 0, "R10 R11 lists empty after done", {e, 8'(log_n)}, 9'h100);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_budget_edge();
    t_reject();
    t_nack();
    t_timeout();
    t_tmo_off();
    t_rearm();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule